// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Timing Generator

This block turns a one-cycle read or write request from synchronous logic into a correctly ordered sequence of chip-select, write-strobe, output-enable, address and bus-drive signals for an asynchronous static RAM. Every interval is set by a parameter in nanoseconds. Each interval is rounded up to whole clock periods of the configured clock period. A write places the address first. It then drives the write strobe for the pulse width with the data already on the bus, and it keeps data and address through a recovery tail. A read places the address, opens chip select and output enable for the access interval, and captures the returned word on the last access cycle.

A request is taken when `reqValid` is high while `busy` is low. The address and write data are latched at that edge and held until the cycle ends. `done` pulses for one cycle when the cycle is over, and a new request may be issued in that same cycle.

Top module: `sram_timing_gen`

## Requirements
- R1: After reset `sramCeN`, `sramWeN` and `sramOeN` are 1, `sramDataOe`, `busy` and `done` are 0.
- R2: A request is accepted at a rising edge where `reqValid` is 1 and `busy` is 0, and `busy` is 1 from the next cycle until the cycle ends. A request raised while `busy` is 1 is ignored: the running cycle keeps its address, its data and its length.
- R3: `sramAddr` equals the accepted address and stays unchanged during every cycle in which `busy` is 1.
- R4: On a write, `sramCeN` is 0 and the address is driven for ceil(20 ns / period) cycles before `sramWeN` falls.
- R5: `sramWeN` stays 0 for max(ceil(60/p), ceil(50/p), ceil(60/p) − setup) cycles, and the accepted write data is on `sramWrData` with `sramDataOe` 1 for the whole pulse.
- R6: After `sramWeN` rises, `sramCeN` stays 0, the data stays driven and the address is held for max(ceil(20/p), ceil(5/p), ceil(120/p) − setup − pulse) cycles. With a 10 ns period a write keeps `busy` high for 12 cycles.
- R7: `sramDataOe` is 1 only during a write cycle, and `sramOeN` is never 0 in a cycle where `sramDataOe` is 1 or `sramWeN` is 0.
- R8: On a read, `sramCeN` and `sramOeN` stay 1 for the setup cycles. Both are then 0 for ceil(100 ns / period) cycles, and `rdData` holds the word on `sramRdData` in the last of those cycles.
- R9: A read keeps `busy` high for at least ceil(120 ns / period) cycles, and for 13 cycles with a 10 ns period, because one inactive tail cycle follows the access.
- R10: `done` is 1 for exactly one cycle, the first cycle after the cycle ends, and `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWrData | input | DATA_W | Write data |
| busy | output | 1 | A cycle is running |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rdData | output | DATA_W | Word captured by the last read |
| sramAddr | output | ADDR_W | Address pins |
| sramWrData | output | DATA_W | Data toward the memory |
| sramDataOe | output | 1 | Drive enable for the data bus |
| sramCeN | output | 1 | Chip select, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramRdData | input | DATA_W | Data returned by the memory |

## Verification
The bench tries isolated writes and reads, a write issued in the very cycle `done` of the previous write shows, and reads that follow writes. Together these separate a wrong phase length from a lost back-to-back request and from a capture taken on the wrong cycle. A request raised mid-cycle to a different address, followed by reads of both addresses, shows whether a stray request leaks into the running cycle or into the memory. Comparing the pins on every clock against a per-cycle queue of expected values places each strobe edge exactly, not merely in order.

// File: rtl/sram_timing_pkg.sv
package sram_timing_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WRECOV, ST_RSETUP, ST_RACCESS, ST_RTAIL
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request address and data
    logic capture;  // sample read data
    logic selOn;    // chip select active
    logic wenOn;    // write strobe active
    logic oenOn;    // output enable active
    logic driveOn;  // data bus driven
    logic busy;
    logic done;
  } strobeT;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
  import sram_timing_pkg::*;
#(
  parameter int CLK_PERIOD_NS   = 10,
  parameter int T_ADDR_SETUP_NS = 20,
  parameter int T_CS_SETUP_NS   = 60,
  parameter int T_WE_PULSE_NS   = 60,
  parameter int T_DATA_SETUP_NS = 50,
  parameter int T_DATA_HOLD_NS  = 5,
  parameter int T_WR_RECOV_NS   = 20,
  parameter int T_WR_CYCLE_NS   = 120,
  parameter int T_RD_CYCLE_NS   = 120,
  parameter int T_ACCESS_NS     = 100
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output strobeT strb
);

  localparam int SETUP_CNT  = maxOf(1, ceilDiv(T_ADDR_SETUP_NS, CLK_PERIOD_NS));
  localparam int PULSE_CNT  = maxOf(1, maxOf(ceilDiv(T_WE_PULSE_NS, CLK_PERIOD_NS),
                              maxOf(ceilDiv(T_DATA_SETUP_NS, CLK_PERIOD_NS),
                                    ceilDiv(T_CS_SETUP_NS, CLK_PERIOD_NS) - SETUP_CNT)));
  localparam int RECOV_CNT  = maxOf(1, maxOf(maxOf(ceilDiv(T_WR_RECOV_NS, CLK_PERIOD_NS),
                                                   ceilDiv(T_DATA_HOLD_NS, CLK_PERIOD_NS)),
                              ceilDiv(T_WR_CYCLE_NS, CLK_PERIOD_NS) - SETUP_CNT - PULSE_CNT));
  localparam int ACCESS_CNT = maxOf(1, ceilDiv(T_ACCESS_NS, CLK_PERIOD_NS));
  localparam int TAIL_CNT   = maxOf(1, ceilDiv(T_RD_CYCLE_NS, CLK_PERIOD_NS) - SETUP_CNT - ACCESS_CNT);
  localparam int MAX_CNT    = maxOf(maxOf(SETUP_CNT, PULSE_CNT),
                                    maxOf(RECOV_CNT, maxOf(ACCESS_CNT, TAIL_CNT)));
  localparam int CNT_W      = $clog2(MAX_CNT + 1);

  phaseT phase, nextPhase;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic doneQ, finish, load, capture, lastCycle;

  always_comb begin
    nextPhase = phase;
    nextCnt   = cnt;
    lastCycle = (cnt == '0);
    load      = 1'b0;
    capture   = 1'b0;
    finish    = 1'b0;
    unique case (phase)
      ST_IDLE: if (reqValid) begin
        load      = 1'b1;
        nextPhase = reqWrite ? ST_WSETUP : ST_RSETUP;
        nextCnt   = CNT_W'(SETUP_CNT - 1);
      end
      ST_WSETUP: if (lastCycle) begin
        nextPhase = ST_WPULSE;
        nextCnt   = CNT_W'(PULSE_CNT - 1);
      end else nextCnt = cnt - CNT_W'(1);
      ST_WPULSE: if (lastCycle) begin
        nextPhase = ST_WRECOV;
        nextCnt   = CNT_W'(RECOV_CNT - 1);
      end else nextCnt = cnt - CNT_W'(1);
      ST_RSETUP: if (lastCycle) begin
        nextPhase = ST_RACCESS;
        nextCnt   = CNT_W'(ACCESS_CNT - 1);
      end else nextCnt = cnt - CNT_W'(1);
      ST_RACCESS: if (lastCycle) begin
        capture   = 1'b1;
        nextPhase = ST_RTAIL;
        nextCnt   = CNT_W'(TAIL_CNT - 1);
      end else nextCnt = cnt - CNT_W'(1);
      ST_WRECOV, ST_RTAIL: if (lastCycle) begin
        finish    = 1'b1;
        nextPhase = ST_IDLE;
      end else nextCnt = cnt - CNT_W'(1);
      default: nextPhase = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      phase <= nextPhase;
      cnt   <= nextCnt;
      doneQ <= finish;
    end
  end

  always_comb begin
    strb.load    = load;
    strb.capture = capture;
    strb.selOn   = (phase == ST_WSETUP) || (phase == ST_WPULSE) ||
                   (phase == ST_WRECOV) || (phase == ST_RACCESS);
    strb.wenOn   = (phase == ST_WPULSE);
    strb.oenOn   = (phase == ST_RACCESS);
    strb.driveOn = (phase == ST_WSETUP) || (phase == ST_WPULSE) || (phase == ST_WRECOV);
    strb.busy    = (phase != ST_IDLE);
    strb.done    = doneQ;
  end

  // checker counters: cycles since the cycle began, length of the strobe run
  logic [15:0] busyAge, weRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyAge <= '0;
      weRun   <= '0;
    end else begin
      busyAge <= !strb.busy ? '0 : ((busyAge == 16'hFFFF) ? busyAge : busyAge + 16'd1);
      weRun   <= !strb.wenOn ? '0 : ((weRun == 16'hFFFF) ? weRun : weRun + 16'd1);
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.busy && reqValid) |=> strb.busy); // R2
  AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.wenOn) |-> (busyAge >= 16'(SETUP_CNT))); // R4
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.wenOn) |-> (weRun >= 16'(PULSE_CNT))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> !strb.busy); // R10

endmodule

// File: rtl/sram_timing_dp.sv
module sram_timing_dp
  import sram_timing_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] sramRdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWrData,
  output logic              sramDataOe,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ, rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      rdDataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ   <= reqAddr;
        wrDataQ <= reqWrData;
      end
      if (strb.capture) rdDataQ <= sramRdData;
    end
  end

  assign sramAddr   = addrQ;
  assign sramWrData = wrDataQ;
  assign sramDataOe = strb.driveOn;
  assign sramCeN    = !strb.selOn;
  assign sramWeN    = !strb.wenOn;
  assign sramOeN    = !strb.oenOn;
  assign rdData     = rdDataQ;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && $past(strb.busy)) |-> $stable(sramAddr)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (sramDataOe && !sramCeN)); // R6
  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (!sramDataOe && sramWeN)); // R7

endmodule

// File: rtl/sram_timing_gen.sv
module sram_timing_gen
  import sram_timing_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 16,
  parameter int CLK_PERIOD_NS   = 10,
  parameter int T_ADDR_SETUP_NS = 20,
  parameter int T_CS_SETUP_NS   = 60,
  parameter int T_WE_PULSE_NS   = 60,
  parameter int T_DATA_SETUP_NS = 50,
  parameter int T_DATA_HOLD_NS  = 5,
  parameter int T_WR_RECOV_NS   = 20,
  parameter int T_WR_CYCLE_NS   = 120,
  parameter int T_RD_CYCLE_NS   = 120,
  parameter int T_ACCESS_NS     = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWrData,
  output logic              sramDataOe,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  input  logic [DATA_W-1:0] sramRdData
);

  strobeT strb;

  sram_timing_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_ADDR_SETUP_NS(T_ADDR_SETUP_NS),
    .T_CS_SETUP_NS(T_CS_SETUP_NS), .T_WE_PULSE_NS(T_WE_PULSE_NS),
    .T_DATA_SETUP_NS(T_DATA_SETUP_NS), .T_DATA_HOLD_NS(T_DATA_HOLD_NS),
    .T_WR_RECOV_NS(T_WR_RECOV_NS), .T_WR_CYCLE_NS(T_WR_CYCLE_NS),
    .T_RD_CYCLE_NS(T_RD_CYCLE_NS), .T_ACCESS_NS(T_ACCESS_NS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .strb(strb)
  );

  sram_timing_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .sramRdData(sramRdData), .sramAddr(sramAddr), .sramWrData(sramWrData),
    .sramDataOe(sramDataOe), .sramCeN(sramCeN), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .rdData(rdData)
  );

  assign busy = strb.busy;
  assign done = strb.done;

endmodule

// File: tb/test_sram_timing_gen.sv
module test_sram_timing_gen;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int PER = 10;

  // expected interval lengths, worked out from the nanosecond rules
  localparam int SETUP  = (20 + PER - 1) / PER;
  localparam int PULSE  = 6;   // max(ceil 60, ceil 50, ceil 60 - setup)
  localparam int RECOV  = 4;   // max(ceil 20, ceil 5, 12 - 2 - 6)
  localparam int ACCESS = (100 + PER - 1) / PER;
  localparam int TAIL   = 1;   // max(1, 12 - 2 - 10)
  localparam int WR_LEN = SETUP + PULSE + RECOV;
  localparam int RD_LEN = SETUP + ACCESS + TAIL;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWrData = '0;
  logic busy, done, sramDataOe, sramCeN, sramWeN, sramOeN;
  logic [DW-1:0] rdData, sramWrData, sramRdData;
  logic [AW-1:0] sramAddr;

  always #5 clk = ~clk;

  sram_timing_gen i_sram_timing_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busy(busy), .done(done),
    .rdData(rdData), .sramAddr(sramAddr), .sramWrData(sramWrData),
    .sramDataOe(sramDataOe), .sramCeN(sramCeN), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramRdData(sramRdData)
  );

  // behavioural memory
  logic [DW-1:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'(i) ^ 16'hA5A5;
  assign sramRdData = (!sramCeN && !sramOeN) ? mem[sramAddr[7:0]] : '0;
  always @(posedge sramWeN) if (!sramCeN) mem[sramAddr[7:0]] <= sramWrData;

  typedef struct packed {
    logic busy, done, ceN, weN, oeN, drv;
  } expT;

  expT expQ[$];
  int checks = 0, errors = 0;
  logic modelBusy = 1'b0;
  logic [AW-1:0] curAddr = '0;
  logic [DW-1:0] curData = '0;
  int busyCnt = 0, weFallAt = -1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic pushN(input int n, input expT e);
    for (int i = 0; i < n; i++) expQ.push_back(e);
  endtask

  // one clock: sample at the falling edge and compare with the model
  task automatic step();
    expT e;
    @(negedge clk);
    e = (expQ.size() > 0) ? expQ.pop_front() : expT'{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    chk(busy == e.busy, "R2 busy", 32'(busy), 32'(e.busy));
    chk(done == e.done, "R10 done", 32'(done), 32'(e.done));
    chk(sramCeN == e.ceN, "R4/R8 ceN", 32'(sramCeN), 32'(e.ceN));
    chk(sramWeN == e.weN, "R5 weN", 32'(sramWeN), 32'(e.weN));
    chk(sramOeN == e.oeN, "R7/R8 oeN", 32'(sramOeN), 32'(e.oeN));
    chk(sramDataOe == e.drv, "R7 drive", 32'(sramDataOe), 32'(e.drv));
    if (e.busy) chk(sramAddr == curAddr, "R3 addr", 32'(sramAddr), 32'(curAddr));
    if (e.drv) chk(sramWrData == curData, "R5 wrData", 32'(sramWrData), 32'(curData));
    if (busy) busyCnt++;
    if (!sramWeN && weFallAt < 0) weFallAt = busyCnt;
    modelBusy = e.busy;
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWrData = d;
    if (!modelBusy) begin
      curAddr = a; curData = d; busyCnt = 0; weFallAt = -1;
      if (wr) begin
        pushN(SETUP, '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
        pushN(PULSE, '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
        pushN(RECOV, '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
      end else begin
        pushN(SETUP, '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0});
        pushN(ACCESS, '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
        pushN(TAIL, '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0});
      end
      pushN(1, '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
    end
    step();
    reqValid = 1'b0;
  endtask

  task automatic finishCycle(input bit wr);
    while (expQ.size() > 0) step();
    if (wr) begin
      chk(busyCnt == WR_LEN, "R6 write length", 32'(busyCnt), 32'(WR_LEN));
      chk(weFallAt == SETUP + 1, "R4 setup before strobe", 32'(weFallAt), 32'(SETUP + 1));
    end else begin
      chk(busyCnt == RD_LEN, "R9 read length", 32'(busyCnt), 32'(RD_LEN));
    end
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input logic [DW-1:0] expv, input string tag);
    issue(1'b0, a, '0);
    finishCycle(1'b0);
    chk(rdData == expv, tag, 32'(rdData), 32'(expv));
  endtask

  initial begin
    #(200000 * PER);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({sramCeN, sramWeN, sramOeN} == 3'b111, "R1 strobes", 32'({sramCeN, sramWeN, sramOeN}), 32'h7);
    chk({sramDataOe, busy, done} == 3'b000, "R1 status", 32'({sramDataOe, busy, done}), 32'h0);
    rstN = 1'b1;
    step(); step();

    // isolated write then read back
    issue(1'b1, 16'h0012, 16'hBEEF);
    finishCycle(1'b1);
    readCheck(16'h0012, 16'hBEEF, "R8 read after write");

    // back-to-back writes: second issued in the done cycle
    issue(1'b1, 16'h0034, 16'h1234);
    finishCycle(1'b1);
    issue(1'b1, 16'h0035, 16'h5678);
    finishCycle(1'b1);
    readCheck(16'h0034, 16'h1234, "R8 first of pair");
    readCheck(16'h0035, 16'h5678, "R8 second of pair");

    // untouched location reads its initial content
    readCheck(16'h0077, 16'h0077 ^ 16'hA5A5, "R8 initial content");

    // R2: stray request during a running write is ignored
    issue(1'b1, 16'h0040, 16'hCAFE);
    step(); step();
    issue(1'b1, 16'h0041, 16'hDEAD);
    finishCycle(1'b1);
    readCheck(16'h0040, 16'hCAFE, "R2 running write intact");
    readCheck(16'h0041, 16'h0041 ^ 16'hA5A5, "R2 stray write ignored");

    // R2: stray request during a read
    issue(1'b0, 16'h0012, '0);
    step(); step(); step();
    issue(1'b1, 16'h0012, 16'h0BAD);
    finishCycle(1'b0);
    chk(rdData == 16'hBEEF, "R2 read unaffected", 32'(rdData), 32'hBEEF);
    readCheck(16'h0012, 16'hBEEF, "R2 stray during read ignored");

    step(); step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule